// File: doc/BRIEF.md
# SD Command Line Serializer

This block drives the single-bit command line of an SD, MMC or SDIO host. It makes its own card clock by dividing the system clock. It turns one command, loaded as a few fields, into a serial frame with one bit per card clock. Software presents a 6-bit command index, a 32-bit primary argument, an extended argument word and a length field, then pulses a start strobe. From that point the block supplies all of the framing. It sends a start bit and a direction bit, then the payload bits. Next it sends a 7-bit CRC that it computes while the bits go out, and last an end bit. It then signals completion.

The payload length is programmable: it is the length field plus one. A long payload continues from the primary argument into the extended word. A request larger than the fields can supply is clamped to the largest length the fields allow. The command line changes only on falling edges of the card clock, so the card samples it on the rising edge. A clock-disable input freezes the card clock and, with it, the frame.

Top module: `sd_cmd_serializer`

## Requirements
- R1: After reset `sd_clk` is 0, `cmd_out` is 1 (idle high), and `busy` and `done` are 0. `cmd_out` is 1 at all times while `busy` is 0.
- R2: Every frame begins with a start bit of value 0, followed by a direction bit of value 1. Both are generated by the block.
- R3: After the direction bit the block sends N payload bits, MSB first, taken from the concatenation {`cmd_idx`[5:0], `arg_pri`[31:0], `arg_ext`[31:0]}. N = `fmt_len` + 1.
- R4: When `fmt_len` + 1 exceeds 70 (6 + 32 + 32), N is clamped to 70. The full frame is then 80 bits long.
- R5: The 7 bits that follow the payload are the CRC7, MSB first. It uses polynomial x^7 + x^3 + 1, starts from zero, and covers the start bit, the direction bit and all payload bits. A command-0 frame with a zero argument therefore ends with the byte 0x95. A command-17 frame with a zero argument ends with 0x55.
- R6: The CRC is followed by an end bit of value 1, and the line stays at 1 afterwards.
- R7: `busy` rises in the cycle after a start strobe is accepted. It falls at the first falling card-clock edge after the end bit has been driven. `done` is a one-cycle pulse in that same cycle.
- R8: A start strobe while `busy` is 1 is ignored. The frame in progress is sent unchanged, even if the fields change.
- R9: `cmd_out` changes only in a system cycle in which `sd_clk` goes from 1 to 0.
- R10: While `clk_dis` is 1, `sd_clk` and `cmd_out` hold their values and the frame makes no progress. When it returns to 0, the frame resumes and completes correctly.
- R11: Each level of `sd_clk` lasts `div` + 1 system clock cycles, so one card clock period is 2·(`div` + 1) cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| clk_dis | input | 1 | Freezes the card clock and the frame when 1 |
| div | input | 8 | Half-period of the card clock, minus one, in system cycles |
| start | input | 1 | Start strobe; sampled when idle |
| cmd_idx | input | 6 | Command index |
| arg_pri | input | 32 | Primary argument |
| arg_ext | input | 32 | Extended argument word |
| fmt_len | input | 7 | Payload length minus one |
| sd_clk | output | 1 | Card clock |
| cmd_out | output | 1 | Serial command line |
| busy | output | 1 | Frame in progress |
| done | output | 1 | One-cycle completion pulse |

## Verification
The bench targets the length corners:
- A one-bit payload would expose a counter that underflows or skips straight to the CRC.
- A payload that crosses into the extended word would catch a design that restarts at the wrong bit of that word.
- An oversized length field would make an unclamped design run off the end of its shift register and send an over-long frame.

The CRC is checked against two well-known command frames, which catches a wrong polynomial, a wrong seed, or framing bits left out of the coverage. A strobe sent mid-frame with altered fields, and a clock-disable pause mid-frame, would show a design that relatches fields or keeps shifting while frozen.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

  typedef enum logic [2:0] {
    FS_IDLE,
    FS_SOF,
    FS_DIR,
    FS_PAY,
    FS_CRC,
    FS_EOF,
    FS_TAIL
  } frm_state_t;

  localparam int IDX_W   = 6;
  localparam int CRC_W   = 7;
  localparam logic [CRC_W-1:0] CRC_POLY = 7'h09;

  function automatic logic [CRC_W-1:0] crc7_next(input logic [CRC_W-1:0] c, input logic b);
    logic fb;
    fb = b ^ c[CRC_W-1];
    return {c[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
  endfunction

endpackage

// File: rtl/sdc_clkgen.sv
module sdc_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_dis,
  input  logic [DIV_W-1:0] div,
  output logic             sd_clk,
  output logic             fall_tick
);

  logic [DIV_W-1:0] cnt_q;
  logic             wrap;

  assign wrap      = !clk_dis && (cnt_q >= div);
  assign fall_tick = wrap && sd_clk;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      sd_clk <= 1'b0;
    end else if (!clk_dis) begin
      if (wrap) begin
        cnt_q  <= '0;
        sd_clk <= ~sd_clk;
      end else begin
        cnt_q <= cnt_q + 1'b1;
      end
    end
  end

  // R10
  clk_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clk_dis) |-> $stable(sd_clk));

endmodule

// File: rtl/sdc_crc7.sv
module sdc_crc7
  import sdc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic clr,
  input  logic upd,
  input  logic bit_in,
  input  logic drain,
  output logic crc_msb
);

  logic [CRC_W-1:0] crc_q;

  always_ff @(posedge clk) begin
    if (rst || clr)  crc_q <= '0;
    else if (upd)    crc_q <= crc7_next(crc_q, bit_in);
    else if (drain)  crc_q <= {crc_q[CRC_W-2:0], 1'b0};
  end

  assign crc_msb = crc_q[CRC_W-1];

  // R5
  crc_mode_excl_chk: assert property (@(posedge clk) disable iff (rst)
    !(upd && drain));

endmodule

// File: rtl/sdc_framer.sv
module sdc_framer
  import sdc_pkg::*;
#(
  parameter int ARG_W = 32,
  parameter int EXT_W = 32,
  parameter int FMT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tick,
  input  logic             start,
  input  logic [IDX_W-1:0] cmd_idx,
  input  logic [ARG_W-1:0] arg_pri,
  input  logic [EXT_W-1:0] arg_ext,
  input  logic [FMT_W-1:0] fmt_len,
  input  logic             crc_msb,
  output logic             crc_clr,
  output logic             crc_upd,
  output logic             crc_bit,
  output logic             crc_drain,
  output logic             cmd_out,
  output logic             busy,
  output logic             done
);

  localparam int MAX_PAY = IDX_W + ARG_W + EXT_W;
  localparam int CNT_W   = $clog2(MAX_PAY + 1) > 3 ? $clog2(MAX_PAY + 1) : 3;

  frm_state_t          st_q;
  logic [MAX_PAY-1:0]  sh_q;
  logic [CNT_W-1:0]    nlen_q;
  logic [CNT_W-1:0]    cnt_q;
  logic [CNT_W-1:0]    nlen_d;
  logic                accept;
  int unsigned         req;

  always_comb begin
    req    = int'(fmt_len) + 1;
    nlen_d = (req > MAX_PAY) ? CNT_W'(MAX_PAY) : CNT_W'(req);
  end

  assign accept = start && (st_q == FS_IDLE);

  // CRC control: clear on accept, absorb framing and payload bits, drain in CRC phase
  always_comb begin
    crc_clr   = accept;
    crc_upd   = 1'b0;
    crc_bit   = 1'b0;
    crc_drain = 1'b0;
    if (tick) begin
      unique case (st_q)
        FS_SOF: begin crc_upd = 1'b1; crc_bit = 1'b0; end
        FS_DIR: begin crc_upd = 1'b1; crc_bit = 1'b1; end
        FS_PAY: begin crc_upd = 1'b1; crc_bit = sh_q[MAX_PAY-1]; end
        FS_CRC: crc_drain = 1'b1;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q    <= FS_IDLE;
      sh_q    <= '0;
      nlen_q  <= '0;
      cnt_q   <= '0;
      cmd_out <= 1'b1;
      busy    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (accept) begin
        st_q   <= FS_SOF;
        sh_q   <= {cmd_idx, arg_pri, arg_ext};
        nlen_q <= nlen_d;
        busy   <= 1'b1;
      end else if (tick) begin
        unique case (st_q)
          FS_SOF: begin
            cmd_out <= 1'b0;
            st_q    <= FS_DIR;
          end
          FS_DIR: begin
            cmd_out <= 1'b1;
            cnt_q   <= nlen_q;
            st_q    <= FS_PAY;
          end
          FS_PAY: begin
            cmd_out <= sh_q[MAX_PAY-1];
            sh_q    <= {sh_q[MAX_PAY-2:0], 1'b0};
            if (cnt_q == CNT_W'(1)) begin
              cnt_q <= CNT_W'(CRC_W);
              st_q  <= FS_CRC;
            end else begin
              cnt_q <= cnt_q - 1'b1;
            end
          end
          FS_CRC: begin
            cmd_out <= crc_msb;
            if (cnt_q == CNT_W'(1)) st_q <= FS_EOF;
            else                    cnt_q <= cnt_q - 1'b1;
          end
          FS_EOF: begin
            cmd_out <= 1'b1;
            st_q    <= FS_TAIL;
          end
          FS_TAIL: begin
            busy <= 1'b0;
            done <= 1'b1;
            st_q <= FS_IDLE;
          end
          default: st_q <= FS_IDLE;
        endcase
      end
    end
  end

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (rst)
    !busy |-> cmd_out);

  // R4
  len_clamp_chk: assert property (@(posedge clk) disable iff (rst)
    nlen_q <= CNT_W'(MAX_PAY));

  // R7
  done_end_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (!busy && $past(busy)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && start) |=> $stable(nlen_q));

endmodule

// File: rtl/sd_cmd_serializer.sv
module sd_cmd_serializer
  import sdc_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int ARG_W = 32,
  parameter int EXT_W = 32,
  parameter int FMT_W = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clk_dis,
  input  logic [DIV_W-1:0] div,
  input  logic             start,
  input  logic [5:0]       cmd_idx,
  input  logic [ARG_W-1:0] arg_pri,
  input  logic [EXT_W-1:0] arg_ext,
  input  logic [FMT_W-1:0] fmt_len,
  output logic             sd_clk,
  output logic             cmd_out,
  output logic             busy,
  output logic             done
);

  logic fall_tick;
  logic crc_clr, crc_upd, crc_bit, crc_drain, crc_msb;

  sdc_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk       (clk),
    .rst       (rst),
    .clk_dis   (clk_dis),
    .div       (div),
    .sd_clk    (sd_clk),
    .fall_tick (fall_tick)
  );

  sdc_crc7 u_crc (
    .clk     (clk),
    .rst     (rst),
    .clr     (crc_clr),
    .upd     (crc_upd),
    .bit_in  (crc_bit),
    .drain   (crc_drain),
    .crc_msb (crc_msb)
  );

  sdc_framer #(.ARG_W(ARG_W), .EXT_W(EXT_W), .FMT_W(FMT_W)) u_framer (
    .clk       (clk),
    .rst       (rst),
    .tick      (fall_tick),
    .start     (start),
    .cmd_idx   (cmd_idx),
    .arg_pri   (arg_pri),
    .arg_ext   (arg_ext),
    .fmt_len   (fmt_len),
    .crc_msb   (crc_msb),
    .crc_clr   (crc_clr),
    .crc_upd   (crc_upd),
    .crc_bit   (crc_bit),
    .crc_drain (crc_drain),
    .cmd_out   (cmd_out),
    .busy      (busy),
    .done      (done)
  );

  // R9
  cmd_on_fall_chk: assert property (@(posedge clk) disable iff (rst)
    !$stable(cmd_out) |-> ($past(sd_clk) && !sd_clk));

  // R10
  cmd_freeze_chk: assert property (@(posedge clk) disable iff (rst)
    $past(clk_dis) |-> $stable(cmd_out));

endmodule

// File: tb/sd_cmd_serializer_bench.sv
module sd_cmd_serializer_bench;

  typedef struct packed {
    logic [5:0]  idx;
    logic [31:0] a0;
    logic [31:0] a1;
    logic [6:0]  fmt;
    logic [7:0]  exp_len;
  } vec_t;

  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{6'h00, 32'h00000000, 32'h00000000, 7'd37,  8'd48},
    '{6'h11, 32'h00000000, 32'h00000000, 7'd37,  8'd48},
    '{6'h2A, 32'hDEADBEEF, 32'h12345678, 7'd37,  8'd48},
    '{6'h3F, 32'hA5A5A5A5, 32'hFFFFFFFF, 7'd0,   8'd11},
    '{6'h08, 32'h000001AA, 32'hC3000000, 7'd45,  8'd56},
    '{6'h15, 32'h80000001, 32'h89ABCDEF, 7'd69,  8'd80},
    '{6'h15, 32'h80000001, 32'h89ABCDEF, 7'd127, 8'd80},
    '{6'h2A, 32'h00000000, 32'h00000000, 7'd5,   8'd16}
  };

  logic clk = 1'b0, rst = 1'b1, clk_dis = 1'b0, start = 1'b0;
  logic [7:0]  div = 8'd1;
  logic [5:0]  cmd_idx = '0;
  logic [31:0] arg_pri = '0, arg_ext = '0;
  logic [6:0]  fmt_len = '0;
  logic sd_clk, cmd_out, busy, done;
  int total = 0, bad = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  sd_cmd_serializer u_sd_cmd_serializer (
    .clk(clk), .rst(rst), .clk_dis(clk_dis), .div(div), .start(start),
    .cmd_idx(cmd_idx), .arg_pri(arg_pri), .arg_ext(arg_ext), .fmt_len(fmt_len),
    .sd_clk(sd_clk), .cmd_out(cmd_out), .busy(busy), .done(done)
  );

  task automatic chk(input bit ok, input string req, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Expected frame from R2, R3, R4, R5, R6
  task automatic model(input logic [5:0] idx, input logic [31:0] a0, input logic [31:0] a1,
                       input logic [6:0] fmt, output logic [127:0] e, output int elen);
    logic [69:0] pay;
    logic [6:0]  c;
    int n;
    pay = {idx, a0, a1};
    n = int'(fmt) + 1;
    if (n > 70) n = 70;
    e = '0; elen = 0; c = '0;
    e = {e[126:0], 1'b0}; elen++; c = {c[5:0], 1'b0} ^ ((1'b0 ^ c[6]) ? 7'h09 : 7'h00);
    e = {e[126:0], 1'b1}; elen++; c = {c[5:0], 1'b0} ^ ((1'b1 ^ c[6]) ? 7'h09 : 7'h00);
    for (int i = 0; i < n; i++) begin
      e = {e[126:0], pay[69-i]}; elen++;
      c = {c[5:0], 1'b0} ^ ((pay[69-i] ^ c[6]) ? 7'h09 : 7'h00);
    end
    for (int i = 0; i < 7; i++) begin e = {e[126:0], c[6-i]}; elen++; end
    e = {e[126:0], 1'b1}; elen++;
  endtask

  // Launch a frame and collect bits on rising card-clock edges until done
  task automatic send(input logic [5:0] idx, input logic [31:0] a0, input logic [31:0] a1,
                      input logic [6:0] fmt, output logic [127:0] got, output int glen,
                      output int edge_bad);
    logic ps, pc;
    bit started;
    @(negedge clk);
    cmd_idx = idx; arg_pri = a0; arg_ext = a1; fmt_len = fmt; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(busy === 1'b1, "R7 busy after strobe", 128'(busy), 128'(1));
    got = '0; glen = 0; edge_bad = 0; started = 0;
    ps = sd_clk; pc = cmd_out;
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (cmd_out !== pc && !(ps && !sd_clk)) edge_bad++;
      if (sd_clk && !ps && (started || !cmd_out)) begin
        started = 1; got = {got[126:0], cmd_out}; glen++;
      end
      ps = sd_clk; pc = cmd_out;
      if (done) break;
    end
    chk(done === 1'b1 && busy === 1'b0, "R7 done with busy low", {busy, done}, 128'b01);
    @(negedge clk);
    chk(done === 1'b0 && cmd_out === 1'b1, "R6 idle high after frame", {done, cmd_out}, 128'b01);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] got, exp;
    int glen, elen, eb;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(sd_clk === 1'b0 && cmd_out === 1'b1 && busy === 1'b0 && done === 1'b0,
        "R1 reset state", {sd_clk, cmd_out, busy, done}, 128'b0100);
    rst = 1'b0;
    repeat (4) @(negedge clk);

    // Vector table walk: R2 R3 R4 R5 R6 R9
    for (int v = 0; v < NV; v++) begin
      send(VEC[v].idx, VEC[v].a0, VEC[v].a1, VEC[v].fmt, got, glen, eb);
      model(VEC[v].idx, VEC[v].a0, VEC[v].a1, VEC[v].fmt, exp, elen);
      chk(glen == int'(VEC[v].exp_len) && elen == glen, "R3/R4 frame length", 128'(glen), 128'(VEC[v].exp_len));
      chk(got == exp, "R2/R3/R5 frame bits", got, exp);
      chk(eb == 0, "R9 change only on sd_clk fall", 128'(eb), 128'(0));
      if (v == 0) chk(got[7:0] == 8'h95, "R5 cmd0 crc byte", 128'(got[7:0]), 128'h95);
      if (v == 1) chk(got[7:0] == 8'h55, "R5 cmd17 crc byte", 128'(got[7:0]), 128'h55);
      if (v == 6) chk(got[glen-1 -: 2] == 2'b01, "R2 start and direction bits", 128'(got[glen-1 -: 2]), 128'b01);
    end

    // R11: card clock period with div=3 is 8 cycles
    div = 8'd3;
    begin
      int t0, t1, cyc;
      logic ps;
      t0 = -1; t1 = -1; cyc = 0; ps = sd_clk;
      for (int k = 0; k < 100 && t1 < 0; k++) begin
        @(negedge clk); cyc++;
        if (sd_clk && !ps) begin if (t0 < 0) t0 = cyc; else t1 = cyc; end
        ps = sd_clk;
      end
      chk(t1 - t0 == 8, "R11 sd_clk period", 128'(t1 - t0), 128'(8));
    end
    div = 8'd1;

    // R8: strobe with other fields in the middle of a frame is ignored
    fork
      send(6'h11, 32'h00000000, 32'h0, 7'd37, got, glen, eb);
      begin
        repeat (30) @(negedge clk);
        cmd_idx = 6'h3F; arg_pri = 32'hFFFFFFFF; fmt_len = 7'd5; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
      end
    join
    model(6'h11, 32'h0, 32'h0, 7'd37, exp, elen);
    chk(got == exp && glen == elen, "R8 strobe while busy ignored", got, exp);

    // R10: freeze mid frame, then resume
    fork
      send(6'h2A, 32'hDEADBEEF, 32'h12345678, 7'd45, got, glen, eb);
      begin
        logic hs, hc;
        int moved;
        repeat (40) @(negedge clk);
        clk_dis = 1'b1;
        @(negedge clk);
        hs = sd_clk; hc = cmd_out; moved = 0;
        repeat (20) begin
          @(negedge clk);
          if (sd_clk !== hs || cmd_out !== hc || done) moved++;
        end
        chk(moved == 0, "R10 frozen while clock disabled", 128'(moved), 128'(0));
        clk_dis = 1'b0;
      end
    join
    model(6'h2A, 32'hDEADBEEF, 32'h12345678, 7'd45, exp, elen);
    chk(got == exp && glen == elen, "R10 frame correct after resume", got, exp);
    chk(eb == 0, "R9 no change off fall edge during pause", 128'(eb), 128'(0));

    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule